// File: doc/BRIEF.md
# Serial Audio Word Receiver with Complementary DAC Code Split

This block sits in front of a pair of complementary current-output converters. It takes audio samples over a three-wire serial link made of a bit clock, a data line and a latch strobe. Every rising clock edge shifts one data bit into a running window that always holds the newest bits. A falling latch strobe freezes that window as a signed sample.

The frozen two's-complement sample is then split into two straight-binary codes of one bit less than the sample width. The "upper" converter code carries the magnitude of positive samples. The "lower" converter code carries negative samples. A separate extra-LSB flag balances the transfer curve around zero. With this split, a signal crossing zero only moves the low bits of one converter.

The new codes appear on a registered parallel output a fixed number of clocks after the strobe falls. A one-cycle strobe marks each update.

Top module: `dacif_serial_rx`

## Requirements
- R1: While the synchronous active-high reset is asserted, and on the first cycle after it, the outputs hold the zero-level codes: `up_code` = 0, `lo_code` all ones, `lo_extra` = 1, `upd_valid` = 0.
- R2: Bits on `ser_data` are taken on each rising clock edge, most significant bit first. The captured sample is the 20 bits taken on the edges strictly before the edge that detects the strobe falling.
- R3: Any number of extra bits before a sample changes nothing. Only the newest 20 bits count.
- R4: A strobe fall is detected only when `ser_le` is sampled high on one edge and low on the next. Holding `ser_le` steadily high, or steadily low, never causes an update.
- R5: Call the edge that detects the fall edge k. The outputs change on edge k+4 (parameter `UPD_DELAY`) and not before.
- R6: For a sample with bit 19 = 0: `up_code` = sample[18:0], `lo_code` is all ones, and `lo_extra` = 1.
- R7: For a sample with bit 19 = 1: `up_code` = 0, `lo_code` = sample[18:0], and `lo_extra` = 0. So 0xFFFFF gives `lo_code` all ones and 0x80000 gives all zeros.
- R8: `upd_valid` is high for exactly the one cycle in which new codes first appear. The codes stay unchanged in all other cycles.
- R9: If a new fall is detected while an update is still pending, the countdown restarts from the new edge. Only the newest captured sample is presented, `UPD_DELAY` edges after that new fall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock; all state moves on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ser_data | input | 1 | Serial sample bit, MSB first |
| ser_le | input | 1 | Latch strobe; a high-to-low change captures the sample |
| lo_code | output | 19 | Straight-binary code for the lower converter |
| up_code | output | 19 | Straight-binary code for the upper converter |
| lo_extra | output | 1 | Extra-LSB weight for the lower converter |
| upd_valid | output | 1 | One-cycle strobe on each output update |

## Verification
The assertions assume that `ser_le` is a clean level sampled on the bit clock. They also assume that two detected falls are always at least two edges apart, which follows from the high-then-low detection rule. The stimulus drives `ser_data` and `ser_le` only on falling clock edges, so every level is settled at the rising edge that samples it. The stimulus holds the strobe low for at least six edges after each fall, except in the deliberate restart case, where it is raised for a single edge.

// File: rtl/dacif_pkg.sv
package dacif_pkg;

  localparam int DEF_WORD_W = 20;
  localparam int DEF_DELAY  = 4;

  // A strobe fall is a high level on one edge followed by a low level on the next.
  function automatic logic fall_seen(input logic prev_lvl, input logic cur_lvl);
    return prev_lvl & ~cur_lvl;
  endfunction

endpackage

// File: rtl/dacif_shift.sv
module dacif_shift #(
  parameter int WORD_W = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ser_data,
  output logic [WORD_W-1:0] shreg
);

  // Newest bit enters at the LSB; older bits move toward the MSB.
  always_ff @(posedge clk) begin
    if (rst) shreg <= '0;
    else     shreg <= {shreg[WORD_W-2:0], ser_data};
  end

endmodule

// File: rtl/dacif_capture.sv
module dacif_capture #(
  parameter int WORD_W = 20,
  parameter int DELAY  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ser_le,
  input  logic [WORD_W-1:0] shreg,
  output logic              fall_evt,
  output logic              fire,
  output logic [WORD_W-1:0] word_q
);

  localparam int CNT_W = $clog2(DELAY + 1);

  logic             le_q;
  logic [CNT_W-1:0] cnt;

  assign fall_evt = dacif_pkg::fall_seen(le_q, ser_le);
  assign fire     = (cnt == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      le_q   <= 1'b0;
      cnt    <= '0;
      word_q <= '0;
    end else begin
      le_q <= ser_le;
      if (fall_evt) begin
        word_q <= shreg;
        cnt    <= CNT_W'(DELAY);
      end else if (cnt != '0) begin
        cnt <= cnt - CNT_W'(1);
      end
    end
  end

  // R4: a detected fall must follow a high strobe sample
  a_r4_fall_edge: assert property (@(posedge clk) disable iff (rst)
    fall_evt |-> ($past(ser_le) && !ser_le));

  // R9: a fall always arms a pending update on the next cycle
  a_r9_rearm: assert property (@(posedge clk) disable iff (rst)
    fall_evt |=> (cnt != '0));

endmodule

// File: rtl/dacif_out.sv
module dacif_out #(
  parameter int WORD_W = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fire,
  input  logic [WORD_W-1:0] word_q,
  output logic [WORD_W-2:0] lo_code,
  output logic [WORD_W-2:0] up_code,
  output logic              lo_extra,
  output logic              upd_valid
);

  localparam int CODE_W = WORD_W - 1;

  // Returns {extra, lower, upper}.
  function automatic logic [2*CODE_W:0] split_word(input logic [WORD_W-1:0] w);
    logic [CODE_W-1:0] mag;
    mag = w[CODE_W-1:0];
    if (w[WORD_W-1]) return {1'b0, mag, {CODE_W{1'b0}}};
    else             return {1'b1, {CODE_W{1'b1}}, mag};
  endfunction

  logic [2*CODE_W:0] next_codes;
  assign next_codes = split_word(word_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_code   <= '1;
      up_code   <= '0;
      lo_extra  <= 1'b1;
      upd_valid <= 1'b0;
    end else begin
      upd_valid <= fire;
      if (fire) begin
        lo_extra <= next_codes[2*CODE_W];
        lo_code  <= next_codes[2*CODE_W-1:CODE_W];
        up_code  <= next_codes[CODE_W-1:0];
      end
    end
  end

  a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (lo_extra && (up_code == '0) && (&lo_code) && !upd_valid));

  a_r6_nonneg_split: assert property (@(posedge clk) disable iff (rst)
    lo_extra |-> (&lo_code));

  a_r7_neg_split: assert property (@(posedge clk) disable iff (rst)
    !lo_extra |-> (up_code == '0));

  a_r8_single_pulse: assert property (@(posedge clk) disable iff (rst)
    upd_valid |=> !upd_valid);

  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    (!upd_valid && !$past(rst)) |-> ($stable(lo_code) && $stable(up_code) && $stable(lo_extra)));

endmodule

// File: rtl/dacif_serial_rx.sv
module dacif_serial_rx #(
  parameter int WORD_W    = dacif_pkg::DEF_WORD_W,
  parameter int UPD_DELAY = dacif_pkg::DEF_DELAY
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ser_data,
  input  logic              ser_le,
  output logic [WORD_W-2:0] lo_code,
  output logic [WORD_W-2:0] up_code,
  output logic              lo_extra,
  output logic              upd_valid
);

  localparam int SF_W = $clog2(UPD_DELAY + 2);

  logic [WORD_W-1:0] shreg;
  logic [WORD_W-1:0] word_q;
  logic              fall_evt;
  logic              fire;

  dacif_shift #(.WORD_W(WORD_W)) u_shift (
    .clk      (clk),
    .rst      (rst),
    .ser_data (ser_data),
    .shreg    (shreg)
  );

  dacif_capture #(.WORD_W(WORD_W), .DELAY(UPD_DELAY)) u_capture (
    .clk      (clk),
    .rst      (rst),
    .ser_le   (ser_le),
    .shreg    (shreg),
    .fall_evt (fall_evt),
    .fire     (fire),
    .word_q   (word_q)
  );

  dacif_out #(.WORD_W(WORD_W)) u_out (
    .clk       (clk),
    .rst       (rst),
    .fire      (fire),
    .word_q    (word_q),
    .lo_code   (lo_code),
    .up_code   (up_code),
    .lo_extra  (lo_extra),
    .upd_valid (upd_valid)
  );

  // Independent edge counter since the last detected fall, saturating.
  logic [SF_W-1:0] since_fall;
  always_ff @(posedge clk) begin
    if (rst)                                 since_fall <= SF_W'(UPD_DELAY + 1);
    else if (fall_evt)                       since_fall <= '0;
    else if (since_fall != SF_W'(UPD_DELAY + 1)) since_fall <= since_fall + SF_W'(1);
  end

  // R5: output strobe lands exactly UPD_DELAY edges after the newest fall
  a_r5_latency: assert property (@(posedge clk) disable iff (rst)
    upd_valid |-> (since_fall == SF_W'(UPD_DELAY)));

endmodule

// File: tb/tb_dacif_serial_rx.sv
module tb_dacif_serial_rx;

  localparam int WW  = 20;
  localparam int CW  = WW - 1;
  localparam int DLY = 4;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst, ser_data, ser_le;
  logic [CW-1:0] lo_code, up_code;
  logic lo_extra, upd_valid;

  dacif_serial_rx #(.WORD_W(WW), .UPD_DELAY(DLY)) dut (
    .clk(clk), .rst(rst), .ser_data(ser_data), .ser_le(ser_le),
    .lo_code(lo_code), .up_code(up_code), .lo_extra(lo_extra), .upd_valid(upd_valid)
  );

  int n_chk = 0;
  int n_bad = 0;
  logic [CW-1:0] e_lo, e_up;
  logic e_ex;
  logic [15:0] lfsr = 16'hACE1;

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  task automatic check(input string req, input logic v_exp);
    n_chk++;
    if (lo_code !== e_lo || up_code !== e_up || lo_extra !== e_ex || upd_valid !== v_exp) begin
      n_bad++;
      $display("FAIL %s: actual lo=%h up=%h ex=%b v=%b expected lo=%h up=%h ex=%b v=%b",
               req, lo_code, up_code, lo_extra, upd_valid, e_lo, e_up, e_ex, v_exp);
    end
  endtask

  // Expected split computed arithmetically from the requirement text.
  task automatic set_exp(input logic [WW-1:0] w);
    int unsigned half = 1 << CW;
    if (int'(w) < half) begin
      e_up = CW'(w);
      e_lo = CW'(half - 1);
      e_ex = 1'b1;
    end else begin
      e_up = '0;
      e_lo = CW'(int'(w) - half);
      e_ex = 1'b0;
    end
  endtask

  task automatic next_bit(output logic b);
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    b = lfsr[0];
  endtask

  task automatic shift_bit(input logic b);
    ser_data = b;
    @(negedge clk);
  endtask

  task automatic shift_rand();
    logic b;
    next_bit(b);
    shift_bit(b);
  endtask

  task automatic send_word(input logic [WW-1:0] w, input int npre);
    string rq;
    rq = w[WW-1] ? "R2 R7" : "R2 R6";
    if (npre > 0) rq = {rq, " R3"};
    ser_le = 1'b1;
    for (int i = 0; i < npre; i++) shift_rand();
    for (int i = WW-1; i >= 0; i--) shift_bit(w[i]);
    ser_le = 1'b0;
    for (int i = 0; i < DLY; i++) shift_rand();   // edges k .. k+3
    check("R5 early", 1'b0);
    set_exp(w);
    shift_rand();                                // edge k+4
    check(rq, 1'b1);
    shift_rand();
    check("R8", 1'b0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=finished");
    summary();
    $finish;
  end

  initial begin
    logic [WW-1:0] a, b;
    rst = 1'b1; ser_data = 1'b0; ser_le = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    e_lo = '1; e_up = '0; e_ex = 1'b1;
    check("R1", 1'b0);
    @(negedge clk);
    check("R1", 1'b0);

    // R4: strobe held low with toggling data
    for (int i = 0; i < 30; i++) begin shift_rand(); check("R4 low", 1'b0); end

    // Corner samples
    send_word(20'h00000, 0);
    send_word(20'h00001, 0);
    send_word(20'h00002, 1);
    send_word(20'h7FFFF, 0);
    send_word(20'h7FFFE, 2);
    send_word(20'hFFFFF, 0);
    send_word(20'hFFFFE, 3);
    send_word(20'h80001, 0);
    send_word(20'h80000, 5);

    // Sweep around zero, varying preamble length
    for (int v = -64; v < 64; v++) send_word(WW'(v), (v + 64) % 5);

    // Pseudo-random samples
    for (int i = 0; i < 40; i++) begin
      logic [WW-1:0] w;
      for (int j = 0; j < WW; j++) begin logic bb; next_bit(bb); w[j] = bb; end
      send_word(w, i % 7);
    end

    // R4: strobe held high
    ser_le = 1'b1;
    for (int i = 0; i < 30; i++) begin shift_rand(); check("R4 high", 1'b0); end

    // R9: restart while an update is pending
    a = 20'h3C5A1;
    for (int i = WW-1; i >= 0; i--) shift_bit(a[i]);
    ser_le = 1'b0;
    shift_bit(1'b1);            // edge k: fall, captures a
    ser_le = 1'b1;
    shift_bit(1'b0);            // edge k+1
    ser_le = 1'b0;
    shift_bit(1'b1);            // edge k+2: fall again
    b = {a[WW-3:0], 1'b1, 1'b0};
    shift_rand(); shift_rand(); // edges k+3, k+4
    check("R9 no stale", 1'b0);
    shift_rand();               // edge k+5
    check("R9 wait", 1'b0);
    set_exp(b);
    shift_rand();               // edge k+6
    check("R9 newest", 1'b1);
    shift_rand();
    check("R8", 1'b0);

    summary();
    $finish;
  end

endmodule